// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch

This block drives one output clock from either of two unrelated source clocks: a fast spread-modulated clock of about 66.66 MHz, which is the default, or a slow unmodulated clock of about 48 MHz. A select input picks the source. When the selection changes, the block does not cut over at once. It parks the output low on a falling edge of the clock that is currently selected. It holds the output low for a guard interval. It then releases the output on a rising edge of the newly selected clock, so that no high or low pulse on the output is shorter than the source phases that form it.

Each source clock has its own control lane. A lane synchronises the select bit, the reset and its peer's state into its own clock domain, and changes its gate enable only on its own falling edge. The two lanes take turns through a request and acknowledge exchange. A lane that has given up the output waits until its peer has taken the output and acknowledged. Because of this, a selection change that arrives in the middle of a handover does not cancel that handover. It is served only after the handover completes. The guard interval is a number of falling edges of the incoming clock, set by a parameter and counted after the synchroniser delay.

Top module: `clk_src_switch`

## Requirements
- R1: While reset is high, and after reset is released with the select at 0, the output follows the fast clock.
- R2: Once a switch has completed, the output follows the slow clock edge for edge when the select is 1, and the fast clock when the select is 0.
- R3: On a switch from fast to slow, the output goes low on a fast falling edge and emits no high pulse shorter than the fast clock's high phase.
- R4: On a switch from fast to slow, the output stays low for at least (PARK_CYCLES+1) slow periods and then rises on a slow rising edge.
- R5: On a switch from slow to fast, the output parks low on a slow falling edge and stays low for at least (PARK_CYCLES+1) fast periods before it rises on a fast rising edge.
- R6: The two source gates are never open at the same time, so no output high pulse is shorter than the fast clock's high phase in either switch direction.
- R7: A select change that arrives while a handover is in progress is held. The incoming clock still takes the output for at least one full high pulse before the block hands back.
- R8: While the select input stays steady, no switch takes place: the output shows no park gap and keeps following the selected clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Default source clock, about 66.66 MHz, spread modulated |
| clk_slow | input | 1 | Alternate source clock, about 48 MHz, no modulation |
| rst | input | 1 | Active-high reset, synchronised into each source domain |
| sel_slow | input | 1 | Source select: 0 picks clk_fast, 1 picks clk_slow |
| clk_out | output | 1 | Switched output clock |

## Verification
The bench sweeps the moment of the select change across many phase offsets of the outgoing clock, in both directions. For each offset it measures the shortest high pulse and the longest low interval on the output. A design that gated off on the wrong edge, or that let both gates overlap, would show a high pulse narrower than a source phase. A design that skipped the guard count would show a park gap shorter than the required number of incoming periods. Other tests flip the select back in the middle of a switch: a design that let the new request cancel the pending handover would never show a wide slow pulse. The bench also asserts reset while the slow clock is selected: a design with the wrong reset state would keep forwarding the slow clock during reset.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Identity of a source lane; the value doubles as the select level that picks it.
  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } cs_src_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/cs_sync.sv
// Multi-stage synchroniser clocked on the falling edge of its domain clock,
// matching the edge on which the lane updates its gate enable.
module cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(negedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cs_lane.sv
// One source lane: owns the gate enable for its clock and takes part in
// the turn-taking exchange with the peer lane.
module cs_lane
  import cs_pkg::*;
#(
  parameter cs_src_e LANE_ID     = SRC_FAST,
  parameter int      SYNC_STAGES = 2,
  parameter int      PARK_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_raw,
  input  logic sel_raw,
  input  logic peer_on,
  input  logic peer_wait,
  output logic lane_on,
  output logic lane_wait
);
  localparam int             CW        = (PARK_CYCLES > 1) ? $clog2(PARK_CYCLES) : 1;
  localparam logic [CW-1:0]  PARK_LAST = CW'(PARK_CYCLES - 1);
  localparam logic           RESET_ON  = (LANE_ID == SRC_FAST);
  localparam logic           MY_SEL    = (LANE_ID == SRC_SLOW);

  logic rst_s;
  logic sel_s;
  logic peer_on_s;
  logic peer_wait_s;
  logic wants_me;
  logic [CW-1:0] park_cnt;

  cs_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (.clk(clk), .d(rst_raw),   .q(rst_s));
  cs_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (.clk(clk), .d(sel_raw),   .q(sel_s));
  cs_sync #(.STAGES(SYNC_STAGES)) u_on_sync  (.clk(clk), .d(peer_on),   .q(peer_on_s));
  cs_sync #(.STAGES(SYNC_STAGES)) u_wt_sync  (.clk(clk), .d(peer_wait), .q(peer_wait_s));

  assign wants_me = (sel_s == MY_SEL);

  always_ff @(negedge clk) begin
    if (rst_s) begin
      lane_on   <= RESET_ON;
      lane_wait <= 1'b0;
      park_cnt  <= '0;
    end else if (lane_on) begin
      // Release only after the peer has acknowledged the previous turn.
      if (!wants_me && !peer_wait_s) begin
        lane_on   <= 1'b0;
        lane_wait <= 1'b1;
      end
      park_cnt <= '0;
    end else if (lane_wait) begin
      // Given away: stay parked until the peer is seen driving.
      if (peer_on_s) begin
        lane_wait <= 1'b0;
      end
    end else if (peer_on_s) begin
      park_cnt <= '0;
    end else if (park_cnt == PARK_LAST) begin
      lane_on  <= 1'b1;
      park_cnt <= '0;
    end else begin
      park_cnt <= park_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PARK_CYCLES = 1
) (
  input  logic clk_fast,
  input  logic clk_slow,
  input  logic rst,
  input  logic sel_slow,
  output logic clk_out
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] lane_on;
  logic [NUM_SRC-1:0] lane_wait;
  logic [NUM_SRC-1:0] gated;

  assign src_clk[SRC_FAST] = clk_fast;
  assign src_clk[SRC_SLOW] = clk_slow;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    cs_lane #(
      .LANE_ID    (cs_src_e'(i)),
      .SYNC_STAGES(SYNC_STAGES),
      .PARK_CYCLES(PARK_CYCLES)
    ) u_lane (
      .clk      (src_clk[i]),
      .rst_raw  (rst),
      .sel_raw  (sel_slow),
      .peer_on  (lane_on[NUM_SRC-1-i]),
      .peer_wait(lane_wait[NUM_SRC-1-i]),
      .lane_on  (lane_on[i]),
      .lane_wait(lane_wait[i])
    );
    // Enable changes only while its own clock is low, so the AND is clean.
    assign gated[i] = src_clk[i] & lane_on[i];
  end

  assign clk_out = |gated;
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk (
  input logic clk_fast,
  input logic clk_slow,
  input logic rst,
  input logic fast_on,
  input logic slow_on
);
  AST_GATES_EXCLUSIVE_FAST: assert property (@(negedge clk_fast) disable iff (rst)
    !(fast_on && slow_on)); // R6

  AST_GATES_EXCLUSIVE_SLOW: assert property (@(negedge clk_slow) disable iff (rst)
    !(fast_on && slow_on)); // R6

  AST_FAST_PARK_HOLDS: assert property (@(negedge clk_fast) disable iff (rst)
    $fell(fast_on) |=> !fast_on); // R3

  AST_SLOW_PARK_HOLDS: assert property (@(negedge clk_slow) disable iff (rst)
    $fell(slow_on) |=> !slow_on); // R5
endmodule

bind clk_src_switch clk_src_switch_chk u_chk (
  .clk_fast(clk_fast),
  .clk_slow(clk_slow),
  .rst     (rst),
  .fast_on (lane_on[0]),
  .slow_on (lane_on[1])
);

// File: tb/clk_src_switch_tb_top.sv
`timescale 1ns/1ps
module clk_src_switch_tb_top;
  localparam int  PARK      = 1;
  localparam real HALF_FAST = 7.5;
  localparam real HALF_SLOW = 10.417;
  localparam real MIN_HIGH  = 7.4;
  localparam int  WD_LIMIT  = 150000;

  logic tb_clk = 1'b0;
  logic clk_fast = 1'b0;
  logic clk_slow = 1'b0;
  logic rst = 1'b1;
  logic sel_slow = 1'b0;
  logic clk_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  real t_rise = 0.0, t_fall = 0.0;
  bit  have_rise = 0, have_fall = 0;
  real max_low = 0.0, min_high = 1.0e9;
  int  wide_cnt = 0;

  clk_src_switch #(.SYNC_STAGES(2), .PARK_CYCLES(PARK)) dut_i (
    .clk_fast(clk_fast),
    .clk_slow(clk_slow),
    .rst     (rst),
    .sel_slow(sel_slow),
    .clk_out (clk_out)
  );

  initial forever #5.0 tb_clk = ~tb_clk;
  initial forever #(HALF_FAST) clk_fast = ~clk_fast;
  initial begin
    #3.1;
    forever #(HALF_SLOW) clk_slow = ~clk_slow;
  end

  // Output pulse monitor
  always @(posedge clk_out) begin
    if (have_fall && ($realtime - t_fall) > max_low) max_low = $realtime - t_fall;
    t_rise = $realtime;
    have_rise = 1;
  end
  always @(negedge clk_out) begin
    if (have_rise) begin
      if (($realtime - t_rise) < min_high) min_high = $realtime - t_rise;
      if (($realtime - t_rise) > 9.0) wide_cnt++;
    end
    t_fall = $realtime;
    have_fall = 1;
  end

  always @(posedge tb_clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    max_low = 0.0;
    min_high = 1.0e9;
    wide_cnt = 0;
  endtask

  // Counts edges where clk_out disagrees with the chosen source.
  task automatic follow(input bit use_slow, input int n, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      if (use_slow) @(posedge clk_slow); else @(posedge clk_fast);
      #1;
      if (clk_out !== 1'b1) bad++;
      if (use_slow) @(negedge clk_slow); else @(negedge clk_fast);
      #1;
      if (clk_out !== 1'b0) bad++;
    end
    check(bad == 0, req, real'(bad), 0.0);
  endtask

  initial begin
    // R1: reset state
    #300;
    follow(0, 8, "R1 fast clock during reset");
    @(posedge tb_clk);
    rst = 1'b0;
    #200;
    follow(0, 8, "R1 fast clock after reset");

    // R8: steady select, no switching
    clear_stats();
    follow(0, 20, "R8 steady fast select");
    check(max_low < HALF_FAST + 0.5, "R8 no park gap on fast", max_low, HALF_FAST);

    // Sweep the select-change phase in both directions
    for (int ph = 0; ph < 10; ph++) begin
      @(posedge clk_fast);
      #(ph * 1.37);
      sel_slow = 1'b1;
      clear_stats();
      #400;
      check(min_high >= MIN_HIGH, "R3 no runt going to slow", min_high, MIN_HIGH);
      check(max_low >= (PARK + 1) * 2.0 * HALF_SLOW, "R4 park gap before slow",
            max_low, (PARK + 1) * 2.0 * HALF_SLOW);
      follow(1, 8, "R2 follows slow");

      @(posedge clk_slow);
      #(ph * 1.9);
      sel_slow = 1'b0;
      clear_stats();
      #400;
      check(min_high >= MIN_HIGH, "R6 no runt going to fast", min_high, MIN_HIGH);
      check(max_low >= (PARK + 1) * 2.0 * HALF_FAST, "R5 park gap before fast",
            max_low, (PARK + 1) * 2.0 * HALF_FAST);
      follow(0, 8, "R2 follows fast");
    end

    // R7: select flips back while the handover is still in progress
    for (int ph = 0; ph < 4; ph++) begin
      @(posedge clk_fast);
      #(2.0 + ph * 3.1);
      sel_slow = 1'b1;
      clear_stats();
      #60;
      sel_slow = 1'b0;
      #700;
      check(wide_cnt >= 1, "R7 slow pulse before handing back", real'(wide_cnt), 1.0);
      check(min_high >= MIN_HIGH, "R6 no runt on aborted request", min_high, MIN_HIGH);
      follow(0, 8, "R7 back on fast");
    end

    // R8: steady slow select
    sel_slow = 1'b1;
    #500;
    clear_stats();
    follow(1, 20, "R8 steady slow select");
    check(max_low < HALF_SLOW + 0.5, "R8 no park gap on slow", max_low, HALF_SLOW);

    // R1: reset while slow is selected brings back the fast clock
    rst = 1'b1;
    #300;
    follow(0, 8, "R1 fast clock on reset from slow");
    sel_slow = 1'b0;
    @(posedge tb_clk);
    rst = 1'b0;
    #200;
    follow(0, 8, "R1 fast clock after second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule